// File: doc/BRIEF.md
# Byte-Wide Bus Loader for a 12-Bit Parallel Converter Code

This block sits between a narrow processor data bus and a parallel digital-to-analog converter whose input word is wider than the bus. A host on an 8-bit bus needs two write cycles to deliver one converter code. The block exposes two memory locations, selected by a single address bit. The low location takes the least significant byte of the code. The high location takes the remaining upper bits.

A low-location write only parks its byte in a private holding register, and the converter pins do not move. A high-location write commits the whole code in one clock: its upper bits and the parked byte reach the converter-facing output register on the same edge. The converter therefore never sees a code that is half old and half new. The holding register keeps its byte after a commit, so a host that changes only the upper bits can write the high location alone.

Reads return the committed output code, one half at a time. Unused bits read as zero. The bus is a plain synchronous strobe interface, so it has no back-pressure. Every access qualified by chip select completes in the clock edge where it is presented.

Top module: `bytebus_dac_latch`

## Requirements
- R1: While the synchronous active-high reset is sampled high, the output code becomes 0 (the zero-output code) and the read data becomes 0, one clock later.
- R2: A write with `cs`=1, `we`=1 and `addr`=0 stores `wdata` as the pending low byte and leaves `dac_code` unchanged.
- R3: A write with `cs`=1, `we`=1 and `addr`=1 sets `dac_code` after that clock edge. `dac_code[11:8]` takes `wdata[3:0]` and `dac_code[7:0]` takes the pending low byte. All 12 bits change on the same edge.
- R4: Bits 7:4 of `wdata` during a write to address 1 have no effect on `dac_code`.
- R5: A bus cycle with `cs`=0 changes neither `dac_code` nor the pending low byte, whatever `we`, `addr` and `wdata` carry.
- R6: A read with `cs`=1, `we`=0 presents data on `rdata` after the next clock edge. At `addr`=0 it returns `dac_code[7:0]`. At `addr`=1 it returns `dac_code[11:8]` in bits 3:0, with bits 7:4 at zero.
- R7: A read changes neither `dac_code` nor the pending low byte.
- R8: The pending low byte survives a commit. Successive writes to address 1 with no address-0 write between them reuse the same low byte.
- R9: `rdata` holds its last value in every cycle that is not a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Chip select; qualifies every bus access |
| we | input | 1 | 1 = write, 0 = read, when `cs` is high |
| addr | input | 1 | 0 = low byte location, 1 = upper bits location |
| wdata | input | 8 | Write data from the host |
| rdata | output | 8 | Registered read-back of the addressed half of the code |
| dac_code | output | 12 | Code driven to the converter's parallel input |

## Verification
A wrong pending byte stays invisible until the next high-location write. It then appears as a wrong low half on `dac_code` one clock after that write. The bench therefore commits every one of the 4096 codes through a full low-then-high write pair. It checks the output both after the low write, where the output must not move, and after the high write. A wrong committed code shows on `dac_code` directly, and on `rdata` one clock after a read. Junk in the ignored data bits and writes without chip select are each followed by a commit or a read, so that a disturbed holding register shows at the ports within two cycles.

// File: rtl/dacb_pkg.sv
package dacb_pkg;

  // Address bit values of the two bus locations
  localparam logic SEL_LO = 1'b0;
  localparam logic SEL_HI = 1'b1;

  // Decoded bus actions for one cycle
  typedef struct packed {
    logic ld_lo;
    logic ld_hi;
    logic rd;
  } dacb_ctl_t;

endpackage

// File: rtl/dacb_decode.sv
module dacb_decode
  import dacb_pkg::*;
(
  input  logic      cs,
  input  logic      we,
  input  logic      addr,
  output dacb_ctl_t ctl
);

  always_comb begin
    ctl       = '0;
    ctl.ld_lo = cs & we & (addr == SEL_LO);
    ctl.ld_hi = cs & we & (addr == SEL_HI);
    ctl.rd    = cs & ~we;
  end

endmodule

// File: rtl/dacb_hold.sv
module dacb_hold #(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [BUS_W-1:0] din,
  output logic [BUS_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= din;
  end

endmodule

// File: rtl/dacb_out.sv
module dacb_out #(
  parameter int BUS_W  = 8,
  parameter int CODE_W = 12,
  localparam int HI_W  = CODE_W - BUS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [HI_W-1:0]   hi_in,
  input  logic [BUS_W-1:0]  lo_in,
  output logic [CODE_W-1:0] code
);

  // Both halves enter on one edge: no partial update is ever visible
  always_ff @(posedge clk) begin
    if (rst)         code <= '0;
    else if (commit) code <= {hi_in, lo_in};
  end

endmodule

// File: rtl/dacb_rdmux.sv
module dacb_rdmux
  import dacb_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int CODE_W = 12,
  localparam int HI_W  = CODE_W - BUS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic              addr,
  input  logic [CODE_W-1:0] code,
  output logic [BUS_W-1:0]  rdata
);

  logic [BUS_W-1:0] hi_word;

  generate
    if (HI_W == BUS_W) begin : g_full
      assign hi_word = code[CODE_W-1:BUS_W];
    end else begin : g_pad
      assign hi_word = {{(BUS_W-HI_W){1'b0}}, code[CODE_W-1:BUS_W]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd)
      rdata <= (addr == SEL_HI) ? hi_word : code[BUS_W-1:0];
  end

endmodule

// File: rtl/bytebus_dac_latch.sv
module bytebus_dac_latch
  import dacb_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              we,
  input  logic              addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output logic [CODE_W-1:0] dac_code
);

  localparam int HI_W = CODE_W - BUS_W;

  initial begin
    if (HI_W < 1 || HI_W > BUS_W)
      $error("CODE_W must exceed BUS_W and be at most twice BUS_W");
  end

  dacb_ctl_t        ctl;
  logic [BUS_W-1:0] lo_pend;

  dacb_decode u_dec (
    .cs   (cs),
    .we   (we),
    .addr (addr),
    .ctl  (ctl)
  );

  dacb_hold #(.BUS_W(BUS_W)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .load (ctl.ld_lo),
    .din  (wdata),
    .q    (lo_pend)
  );

  dacb_out #(.BUS_W(BUS_W), .CODE_W(CODE_W)) u_out (
    .clk    (clk),
    .rst    (rst),
    .commit (ctl.ld_hi),
    .hi_in  (wdata[HI_W-1:0]),
    .lo_in  (lo_pend),
    .code   (dac_code)
  );

  dacb_rdmux #(.BUS_W(BUS_W), .CODE_W(CODE_W)) u_rd (
    .clk   (clk),
    .rst   (rst),
    .rd    (ctl.rd),
    .addr  (addr),
    .code  (dac_code),
    .rdata (rdata)
  );

endmodule

// File: rtl/dacb_chk.sv
module dacb_chk #(
  parameter int BUS_W  = 8,
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              cs,
  input logic              we,
  input logic              addr,
  input logic [BUS_W-1:0]  wdata,
  input logic [BUS_W-1:0]  rdata,
  input logic [CODE_W-1:0] dac_code
);

  localparam int HI_W = CODE_W - BUS_W;

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (dac_code == '0 && rdata == '0));

  // R2
  lo_write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cs && we && !addr) |=> $stable(dac_code));

  // R3
  hi_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (cs && we && addr) |=> dac_code[CODE_W-1:BUS_W] == $past(wdata[HI_W-1:0]));

  // R5
  no_select_chk: assert property (@(posedge clk) disable iff (rst)
    !cs |=> $stable(dac_code));

  // R6
  rd_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (cs && !we && !addr) |=> rdata == $past(dac_code[BUS_W-1:0]));

  // R6
  rd_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (cs && !we && addr) |=> rdata == BUS_W'($past(dac_code) >> BUS_W));

  // R7
  read_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cs && !we) |=> $stable(dac_code));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(cs && !we) |=> $stable(rdata));

endmodule

bind bytebus_dac_latch dacb_chk #(.BUS_W(BUS_W), .CODE_W(CODE_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .cs       (cs),
  .we       (we),
  .addr     (addr),
  .wdata    (wdata),
  .rdata    (rdata),
  .dac_code (dac_code)
);

// File: tb/bytebus_dac_latch_tb_top.sv
module bytebus_dac_latch_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs = 1'b0;
  logic        we = 1'b0;
  logic        addr = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic [11:0] dac_code;

  int compared = 0;
  int mismatched = 0;

  always #2.5 clk = ~clk;

  bytebus_dac_latch dut_i (
    .clk      (clk),
    .rst      (rst),
    .cs       (cs),
    .we       (we),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .dac_code (dac_code)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Drive one bus cycle at a falling edge; return at the next falling edge
  task automatic bus_cycle(input logic c, input logic w, input logic a, input logic [7:0] d);
    @(negedge clk);
    cs = c; we = w; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0; addr = 1'b0; wdata = 8'h00;
  endtask

  initial begin
    #1_000_000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int exp_code;
    int pend;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 code", dac_code, 0);
    check("R1 rdata", rdata, 0);
    exp_code = 0;
    pend = 0;

    // R2/R3/R4: sweep every code, junk in ignored bits
    for (int i = 0; i < 4096; i++) begin
      int lo = i & 8'hFF;
      int hi = i >> 8;
      int junk = ((i * 7) + 3) & 4'hF;
      bus_cycle(1'b1, 1'b1, 1'b0, 8'(lo));
      pend = lo;
      if ((i & 15) == 0) check("R2 low write leaves code", dac_code, exp_code);
      bus_cycle(1'b1, 1'b1, 1'b1, 8'((junk << 4) | hi));
      exp_code = (hi << 8) | pend;
      check("R3/R4 committed code", dac_code, exp_code);
      if ((i % 37) == 0) begin
        bus_cycle(1'b1, 1'b0, 1'b0, 8'hFF);
        check("R6 read low", rdata, exp_code & 8'hFF);
        bus_cycle(1'b1, 1'b0, 1'b1, 8'hFF);
        check("R6 read high", rdata, exp_code >> 8);
        check("R7 read leaves code", dac_code, exp_code);
      end
    end

    // R8: pending byte reused across commits
    bus_cycle(1'b1, 1'b1, 1'b0, 8'hA5);
    bus_cycle(1'b1, 1'b1, 1'b1, 8'h03);
    check("R8 first commit", dac_code, 12'h3A5);
    bus_cycle(1'b1, 1'b1, 1'b1, 8'hFC);
    check("R8 second commit reuses low", dac_code, 12'hCA5);

    // R5: unselected cycles of every shape
    for (int k = 0; k < 8; k++) begin
      bus_cycle(1'b0, k[0], k[1], 8'(8'h5A ^ (k * 8'h11)));
      check("R5 no-cs code", dac_code, 12'hCA5);
    end
    bus_cycle(1'b1, 1'b1, 1'b1, 8'h01);
    check("R5 pending byte untouched", dac_code, 12'h1A5);

    // R7: reads do not disturb pending byte
    bus_cycle(1'b1, 1'b0, 1'b0, 8'h00);
    bus_cycle(1'b1, 1'b1, 1'b1, 8'h07);
    check("R7 pending after read", dac_code, 12'h7A5);

    // R9: rdata holds across non-read cycles
    bus_cycle(1'b1, 1'b0, 1'b1, 8'h00);
    check("R6 read high padded", rdata, 8'h07);
    bus_cycle(1'b1, 1'b1, 1'b0, 8'h3C);
    bus_cycle(1'b0, 1'b0, 1'b0, 8'h00);
    bus_cycle(1'b1, 1'b1, 1'b1, 8'h0E);
    check("R9 rdata held", rdata, 8'h07);
    check("R3 final code", dac_code, 12'hE3C);

    // R1: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 code after reset", dac_code, 0);
    check("R1 rdata after reset", rdata, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule